// File: doc/BRIEF.md
# Platform Interrupt Controller Core

This block collects a parameterised set of external interrupt sources and distributes them to several target contexts. A context is one privilege level of one hardware thread. Every source reaches every context. Each source carries a programmable priority. Each context holds its own per-source enable mask and its own priority threshold, and drives one interrupt request line toward its thread.

A context services an interrupt in two steps. It first reads its claim register, which returns the identifier of the best eligible source and takes that source out of play. Once the handler has finished, it writes the same identifier back to the claim register, and the source may then raise a request again. Each source is built either as edge-sensitive or as level-sensitive, chosen by a parameter mask. Source identifier 0 is reserved and means that nothing is pending.

Configuration and the claim/complete handshake use one word-addressed register port. The port has separate read and write strobes, and read data is registered.

Top module: `irqc_top`

## Requirements
- R1: After reset, every priority, enable mask and threshold reads 0, every interrupt line is low, and a claim returns 0.
- R2: Word address map. Address 0x00+s holds the 3-bit priority of source s, for s from 1 to N; address 0x00 always reads 0. Address 0x40+c holds the enable mask of context c, where bit s enables source s and bit 0 always reads 0. Address 0x80+c holds the 3-bit threshold of context c. Address 0xC0+c is the claim/complete register of context c. Read data appears on the clock edge that samples the read strobe and holds until the next read.
- R3: The line of context c is high exactly when some source is pending, enabled for c, and has a nonzero priority that is greater than or equal to the threshold of c.
- R4: A read of the claim register returns the eligible source (as defined in R3) with the highest priority. Among equal priorities the lowest identifier wins. If no source is eligible, the read returns 0 and claims nothing.
- R5: A claim clears the pending state of the returned source on that clock edge. The source cannot become pending again until it is completed, so a line with no other eligible source falls right after the claim.
- R6: A write of an identifier that is not currently claimed, including 0 and identifiers above N, has no effect on any source.
- R7: An edge source becomes pending on a rising input. A rising edge that arrives while the source is claimed is discarded, and an input that is still high at completion does not pend the source again.
- R8: A level source becomes pending whenever its input is high and it is not claimed. If its input is still high when it is completed, it pends again one cycle after the completion write.
- R9: A source with priority 0 never drives any line and is never returned by a claim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | N_SRC | Source inputs; bit s is source s (1..N_SRC) |
| irq_o | output | N_CTX | Interrupt request line of each context |
| reg_wr | input | 1 | Register write strobe; a write to the claim register completes a source |
| reg_rd | input | 1 | Register read strobe; a read of the claim register performs a claim |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |

## Verification
Suppose a source stays pending after a claim, or its in-service mark is lost. Then the next claim read, one cycle later, returns that identifier a second time, and the context line stays high where it should fall. A wrong arbitration order becomes visible in the very first claim read of a sweep in which several sources share a priority. A broken edge detector or a broken level re-arm shows up in the claim returned right after the completion write and one extra cycle. Every such fault is therefore visible at the ports within two or three cycles of the stimulus that exposes it.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  // Register regions, selected by the two top address bits
  typedef enum logic [1:0] {
    REG_PRIO  = 2'd0,
    REG_EN    = 2'd1,
    REG_THR   = 2'd2,
    REG_CLAIM = 2'd3
  } irqc_region_e;

  // A source may interrupt a context when it is pending, enabled there,
  // has nonzero priority and meets the context threshold.
  function automatic logic src_eligible(logic pend, logic en,
                                        logic [7:0] prio, logic [7:0] thr);
    return pend && en && (prio != 8'd0) && (prio >= thr);
  endfunction

  // Strictly greater priority replaces the current best; scanning upward
  // in identifier therefore keeps the lowest identifier on a tie.
  function automatic logic outranks(logic ok, logic [7:0] prio,
                                    logic [7:0] best);
    return ok && (prio > best);
  endfunction

endpackage

// File: rtl/irqc_gateway.sv
module irqc_gateway #(
  parameter bit EDGE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_i,
  input  logic claim_i,
  input  logic complete_i,
  output logic pending_o,
  output logic in_service_o
);

  logic set_req;

  generate
    if (EDGE) begin : g_edge
      logic src_prev;
      always_ff @(posedge clk) begin
        if (!rst_n) src_prev <= 1'b0;
        else        src_prev <= src_i;
      end
      assign set_req = src_i && !src_prev;
    end else begin : g_level
      assign set_req = src_i;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_o    <= 1'b0;
      in_service_o <= 1'b0;
    end else if (claim_i) begin
      pending_o    <= 1'b0;
      in_service_o <= 1'b1;
    end else begin
      if (set_req && !in_service_o) pending_o <= 1'b1;
      if (complete_i)               in_service_o <= 1'b0;
    end
  end

endmodule

// File: rtl/irqc_target.sv
module irqc_target
  import irqc_pkg::*;
#(
  parameter int N_SRC  = 10,
  parameter int PRIO_W = 3,
  localparam int ID_W  = $clog2(N_SRC + 1)
) (
  input  logic [N_SRC:0]              pending,
  input  logic [N_SRC:0]              enable,
  input  logic [(N_SRC+1)*PRIO_W-1:0] prio_flat,
  input  logic [PRIO_W-1:0]           threshold,
  output logic [ID_W-1:0]             best_id,
  output logic                        irq
);

  logic [7:0] best_prio;

  always_comb begin
    best_prio = 8'd0;
    best_id   = '0;
    for (int s = 1; s <= N_SRC; s++) begin
      logic [7:0] p;
      logic       ok;
      p  = 8'(prio_flat[s*PRIO_W +: PRIO_W]);
      ok = src_eligible(pending[s], enable[s], p, 8'(threshold));
      if (outranks(ok, p, best_prio)) begin
        best_prio = p;
        best_id   = ID_W'(s);
      end
    end
  end

  assign irq = (best_id != '0);

endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int          N_SRC     = 10,
  parameter int          N_CTX     = 2,
  parameter int          PRIO_W    = 3,
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 32,
  parameter logic [31:0] EDGE_MASK = 32'h0000_07C0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC:1]    src_i,
  output logic [N_CTX-1:0]  irq_o,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);

  localparam int ID_W  = $clog2(N_SRC + 1);
  localparam int IDX_W = ADDR_W - 2;

  // Configuration state
  logic [PRIO_W-1:0] prio_q [N_SRC+1];
  logic [N_SRC:0]    en_q   [N_CTX];
  logic [PRIO_W-1:0] thr_q  [N_CTX];
  logic [(N_SRC+1)*PRIO_W-1:0] prio_flat;

  // Named events for the checker
  logic [N_SRC:0] pending;
  logic [N_SRC:0] in_service;
  logic [N_SRC:0] claim_pulse;
  logic [N_SRC:0] complete_pulse;
  logic [ID_W-1:0] best_id [N_CTX];

  irqc_region_e     region;
  logic [IDX_W-1:0] idx;
  logic             ctx_ok;
  logic             claim_hit;
  logic             cmpl_hit;
  logic [ID_W-1:0]  claim_id;
  logic [DATA_W-1:0] rd_value;

  assign region = irqc_region_e'(reg_addr[ADDR_W-1 -: 2]);
  assign idx    = reg_addr[IDX_W-1:0];
  assign ctx_ok = (idx < IDX_W'(N_CTX));

  assign claim_hit = reg_rd && (region == REG_CLAIM) && ctx_ok;
  assign cmpl_hit  = reg_wr && (region == REG_CLAIM) && ctx_ok;

  always_comb begin
    for (int s = 0; s <= N_SRC; s++) prio_flat[s*PRIO_W +: PRIO_W] = prio_q[s];
  end

  // Best identifier of the addressed context
  always_comb begin
    claim_id = '0;
    for (int c = 0; c < N_CTX; c++)
      if (idx == IDX_W'(c)) claim_id = best_id[c];
  end

  always_comb begin
    claim_pulse    = '0;
    complete_pulse = '0;
    for (int s = 1; s <= N_SRC; s++) begin
      claim_pulse[s]    = claim_hit && (claim_id == ID_W'(s));
      complete_pulse[s] = cmpl_hit && (reg_wdata == DATA_W'(s)) && in_service[s];
    end
  end

  // Per-source gateways
  assign pending[0]    = 1'b0;
  assign in_service[0] = 1'b0;

  generate
    for (genvar s = 1; s <= N_SRC; s++) begin : g_src
      irqc_gateway #(.EDGE(EDGE_MASK[s])) u_gw (
        .clk          (clk),
        .rst_n        (rst_n),
        .src_i        (src_i[s]),
        .claim_i      (claim_pulse[s]),
        .complete_i   (complete_pulse[s]),
        .pending_o    (pending[s]),
        .in_service_o (in_service[s])
      );
    end
  endgenerate

  // Per-context arbiters
  generate
    for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
      irqc_target #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_tgt (
        .pending   (pending),
        .enable    (en_q[c]),
        .prio_flat (prio_flat),
        .threshold (thr_q[c]),
        .best_id   (best_id[c]),
        .irq       (irq_o[c])
      );
    end
  endgenerate

  // Configuration writes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s <= N_SRC; s++) prio_q[s] <= '0;
      for (int c = 0; c < N_CTX; c++) begin
        en_q[c]  <= '0;
        thr_q[c] <= '0;
      end
    end else if (reg_wr) begin
      case (region)
        REG_PRIO: begin
          for (int s = 1; s <= N_SRC; s++)
            if (idx == IDX_W'(s)) prio_q[s] <= reg_wdata[PRIO_W-1:0];
        end
        REG_EN: begin
          for (int c = 0; c < N_CTX; c++)
            if (idx == IDX_W'(c)) en_q[c] <= {reg_wdata[N_SRC:1], 1'b0};
        end
        REG_THR: begin
          for (int c = 0; c < N_CTX; c++)
            if (idx == IDX_W'(c)) thr_q[c] <= reg_wdata[PRIO_W-1:0];
        end
        default: ;
      endcase
    end
  end

  // Read mux
  always_comb begin
    rd_value = '0;
    case (region)
      REG_PRIO: begin
        for (int s = 0; s <= N_SRC; s++)
          if (idx == IDX_W'(s)) rd_value = DATA_W'(prio_q[s]);
      end
      REG_EN: begin
        for (int c = 0; c < N_CTX; c++)
          if (idx == IDX_W'(c)) rd_value = DATA_W'(en_q[c]);
      end
      REG_THR: begin
        for (int c = 0; c < N_CTX; c++)
          if (idx == IDX_W'(c)) rd_value = DATA_W'(thr_q[c]);
      end
      REG_CLAIM: rd_value = ctx_ok ? DATA_W'(claim_id) : '0;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_value;
  end

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int N_SRC = 10,
  parameter int N_CTX = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC:0]   pending,
  input logic [N_SRC:0]   in_service,
  input logic [N_SRC:0]   claim_pulse,
  input logic [N_SRC:0]   complete_pulse,
  input logic [N_CTX-1:0] irq
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq == '0));

  // R5
  pend_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending & in_service) == '0);

  // R4
  claim_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(claim_pulse));

  // R4
  claim_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_pulse & ~pending) == '0);

  // R5
  claim_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|claim_pulse) |=> (((in_service & $past(claim_pulse)) == $past(claim_pulse))
                        && ((pending & $past(claim_pulse)) == '0)));

  // R6
  service_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(in_service & ~complete_pulse)) |=>
      ((in_service & $past(in_service & ~complete_pulse))
       == $past(in_service & ~complete_pulse)));

endmodule

bind irqc_top irqc_chk #(.N_SRC(N_SRC), .N_CTX(N_CTX)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .pending        (pending),
  .in_service     (in_service),
  .claim_pulse    (claim_pulse),
  .complete_pulse (complete_pulse),
  .irq            (irq_o)
);

// File: tb/tb_irqc_top.sv
`timescale 1ns/1ps
module tb_irqc_top;

  localparam int N = 10;
  localparam int C = 2;
  localparam logic [31:0] EDGES = 32'h0000_07C0;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N:1]    src = '0;
  logic [C-1:0]  irq;
  logic          reg_wr = 1'b0;
  logic          reg_rd = 1'b0;
  logic [7:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;

  always #2 clk = ~clk;

  irqc_top dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .irq_o(irq),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  int errs = 0;
  int checks = 0;
  bit done = 0;

  int m_prio [N+1];
  bit m_en   [C][N+1];
  int m_thr  [C];
  bit m_pend [N+1];
  bit m_serv [N+1];
  bit m_src  [N+1];

  function automatic int exp_best(int c);
    int bp = 0;
    int id = 0;
    for (int s = 1; s <= N; s++)
      if (m_pend[s] && m_en[c][s] && m_prio[s] != 0 && m_prio[s] >= m_thr[c]
          && m_prio[s] > bp) begin
        bp = m_prio[s];
        id = s;
      end
    return id;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'(a); reg_wdata = 32'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 8'(a);
    @(negedge clk);
    reg_rd = 1'b0;
    d = int'(reg_rdata);
  endtask

  task automatic set_prio(int s, int p);
    wr(8'h00 + s, p);
    m_prio[s] = p & 7;
  endtask

  task automatic set_en(int c, int mask);
    wr(8'h40 + c, mask);
    for (int s = 1; s <= N; s++) m_en[c][s] = mask[s];
  endtask

  task automatic set_thr(int c, int t);
    wr(8'h80 + c, t);
    m_thr[c] = t & 7;
  endtask

  task automatic set_src(int s, bit v);
    @(negedge clk);
    src[s] = v;
    if (!m_serv[s]) begin
      if (EDGES[s] ? (v && !m_src[s]) : v) m_pend[s] = 1'b1;
    end
    m_src[s] = v;
    @(negedge clk);
  endtask

  task automatic check_irqs(string req);
    for (int c = 0; c < C; c++) chk(req, int'(irq[c]), int'(exp_best(c) != 0));
  endtask

  task automatic claim(int c, string req);
    int e;
    int d;
    e = exp_best(c);
    rd(8'hC0 + c, d);
    chk(req, d, e);
    if (e != 0) begin
      m_pend[e] = 1'b0;
      m_serv[e] = 1'b1;
    end
  endtask

  task automatic complete(int c, int id);
    wr(8'hC0 + c, id);
    if (id >= 1 && id <= N) begin
      if (m_serv[id]) begin
        m_serv[id] = 1'b0;
        if (!EDGES[id] && m_src[id]) m_pend[id] = 1'b1;
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int d;
    for (int s = 0; s <= N; s++) begin
      m_prio[s] = 0; m_pend[s] = 0; m_serv[s] = 0; m_src[s] = 0;
      for (int c = 0; c < C; c++) m_en[c][s] = 0;
    end
    for (int c = 0; c < C; c++) m_thr[c] = 0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 irq", int'(irq), 0);
    rd(8'h03, d); chk("R1 prio", d, 0);
    rd(8'h41, d); chk("R1 enable", d, 0);
    rd(8'h80, d); chk("R1 threshold", d, 0);
    rd(8'hC0, d); chk("R1 claim", d, 0);

    // R2: priority map and readback
    for (int s = 1; s <= N; s++) set_prio(s, (s * 3) % 8);
    for (int s = 0; s <= N; s++) begin
      rd(8'h00 + s, d);
      chk("R2 prio readback", d, (s * 3) % 8);
    end
    set_en(0, 32'h7FF);
    rd(8'h40, d); chk("R2 enable bit0 masked", d, 32'h7FE);
    set_en(1, 32'h554);
    rd(8'h41, d); chk("R2 enable ctx1", d, 32'h554);
    set_thr(0, 0);
    set_thr(1, 4);
    rd(8'h81, d); chk("R2 threshold", d, 4);

    // R9: priority-0 source alone never interrupts
    set_src(8, 1'b1);
    check_irqs("R9 prio0 line");
    claim(0, "R9 prio0 claim");

    // R3: all sources raised, threshold sweep on context 0
    for (int s = 1; s <= N; s++) if (s != 8) set_src(s, 1'b1);
    for (int t = 0; t < 8; t++) begin
      set_thr(0, t);
      check_irqs("R3 threshold sweep");
    end
    set_thr(0, 0);

    // R4/R5: drain context 1 then context 0 by claims
    for (int k = 0; k < 4; k++) begin
      claim(1, "R4 ctx1 order");
      check_irqs("R5 line after claim");
    end
    for (int k = 0; k < 8; k++) begin
      claim(0, "R4 ctx0 order");
      check_irqs("R5 line after claim");
    end

    // R6: completions of unclaimed or invalid identifiers
    complete(0, 8);
    complete(0, 0);
    complete(1, 15);
    check_irqs("R6 ignored complete");
    claim(0, "R6 nothing released");

    // R8: level sources still high pend again after completion
    for (int s = 1; s <= 5; s++) complete(0, s);
    check_irqs("R8 level rearm line");
    // R7: edge sources still high do not pend again
    for (int s = 6; s <= 10; s++) complete(1, s);
    check_irqs("R7 edge no rearm line");
    claim(0, "R8 level rearm claim");
    claim(0, "R8 level rearm claim 2");

    // R7: fresh edge, then an edge during service is dropped
    set_src(10, 1'b0);
    set_src(10, 1'b1);
    claim(1, "R7 edge tie");
    claim(1, "R7 edge claim");
    set_src(10, 1'b0);
    set_src(10, 1'b1);
    complete(1, 10);
    check_irqs("R7 edge in service dropped");
    claim(1, "R7 after drop");
    claim(1, "R7 drained");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule